// File: doc/BRIEF.md
# Four-Way Write-Through Data Cache Controller

This block is a data cache placed between a processor-side request port and an external memory bus. It holds a configurable number of sets, each with four ways of sixteen-byte lines. A read that matches a valid line is answered straight from the cache, with no bus traffic. A read that misses fetches the whole line over the bus and stores it, but only when the request is flagged cacheable. An uncacheable read miss makes a single bus read and leaves the cache as it was.

Writes never stay in the cache alone. Each write, hit or miss, makes exactly one bus write. A write that hits also updates the cached word, and a write that misses allocates nothing. When a fill needs a way, an empty way in the set is used first. If the set is full, a three-bit tree approximation of least-recent use picks the victim. A one-cycle invalidate input empties the whole cache.

Both ports use a valid/ready handshake, with one bus transaction outstanding at a time. The processor holds its request stable until `cpu_ready` is high. A fill moves one word per bus handshake.

Top module: `wt_cache_ctrl`

## Requirements
- R1: A read whose line is resident is answered with `cpu_ready` high in the cycle the request is presented, with the cached word, and with no bus cycle.
- R2: A cacheable read miss issues four bus reads to line base + 4·k for k = 0,1,2,3 in that order. It then raises `cpu_ready` with the requested word, and the line is resident afterwards.
- R3: An uncacheable read miss issues exactly one bus read at the request address, returns that word, and allocates nothing, so a repeat of it misses again.
- R4: Every write, whether it hits or misses and whether or not it is cacheable, issues exactly one bus write carrying the request address and data before `cpu_ready` is raised.
- R5: A write that hits updates the cached word, so a later read hit returns the written value.
- R6: A write that misses allocates no line, so a later cacheable read of that line takes a full four-beat fill.
- R7: A fill places the line in the lowest-numbered invalid way of the set when one exists. Four distinct lines filled into an empty set therefore all stay resident.
- R8: When all four ways are valid, the victim comes from the set's tree bits {root, left, right}. Root 0 picks way 0 or 1 (way 1 if left = 1), and root 1 picks way 2 or 3 (way 3 if right = 1).
- R9: Every read hit, write hit and fill updates the tree bits. Accessing way 0 or 1 sets root to 1 and left to 1 for way 0 or 0 for way 1. Accessing way 2 or 3 sets root to 0 and right to 1 for way 2 or 0 for way 3.
- R10: One cycle of `inv_all` clears every valid bit and every tree bit at the next edge.
- R11: Once `bus_valid` is raised it stays high, with address and direction unchanged, until `bus_ready`. Only one bus transaction is in flight, and `cpu_ready` is never high while `bus_valid` is high.
- R12: After reset, `cpu_ready` and `bus_valid` are low, all lines are invalid and all tree bits are zero, and `cpu_ready` is raised only while a request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inv_all | input | 1 | Invalidate every line and clear replacement state |
| cpu_valid | input | 1 | Processor request present, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_cacheable | input | 1 | A read miss may allocate a line |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on reads |
| bus_valid | output | 1 | Bus transaction requested |
| bus_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ready | input | 1 | Bus accepts or completes the transaction |
| bus_rdata | input | DATA_W | Bus read data, valid with `bus_ready` |

## Verification
The bench builds the controller with four sets, four words per line and 32-bit addresses and data, and it only uses the low kilobyte of the address space. A bench memory of 256 words can therefore mirror everything the bus can reach, and every read's expected data is a plain lookup. Only six tags are used per set, so with four sets the sets overflow constantly. A reference model of valid bits, tags and tree bits then predicts, for every access, whether it hits and how many bus beats of each kind it costs. This covers invalid-first allocation, tree-based eviction, touch updates, uncacheable bypass, write-miss non-allocation and invalidation across directed and pseudo-random access streams.

// File: rtl/wtc_pkg.sv
// Shared definitions for the write-through cache controller: way count,
// controller states and the three-bit tree replacement helpers.
// Assumes exactly four ways; the tree helpers are written for that shape.
package wtc_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_BYPASS = 3'd2,
        ST_WRITE  = 3'd3,
        ST_RESP   = 3'd4
    } ctl_state_e;

    // Point the tree away from the way just used: bit0 = root, bit1 = left pair, bit2 = right pair.
    function automatic logic [2:0] plru_touch(input logic [2:0] cur, input logic [WAY_W-1:0] way);
        logic [2:0] nxt;
        nxt    = cur;
        nxt[0] = ~way[1];
        if (way[1] == 1'b0) begin
            nxt[1] = ~way[0];
        end else begin
            nxt[2] = ~way[0];
        end
        return nxt;
    endfunction

    // Follow the tree to the way it currently points at.
    function automatic logic [WAY_W-1:0] plru_pick(input logic [2:0] cur);
        return {cur[0], (cur[0] ? cur[2] : cur[1])};
    endfunction
endpackage

// File: rtl/wtc_tag_array.sv
// Tag and valid storage for all sets and ways, with a combinational lookup
// of one set. Assumes at most one way of a set holds a given tag, which the
// controller guarantees by only filling on a miss. Tags are not reset; valid
// bits are, and invalidate-all takes priority over a fill in the same cycle.
module wtc_tag_array
    import wtc_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 25,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inv_all,
    input  logic [IDX_W-1:0]      lk_idx,
    input  logic [TAG_W-1:0]      lk_tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic [WAYS-1:0]       set_vld,
    input  logic                  fill_en,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic [WAY_W-1:0]      fill_way,
    input  logic [TAG_W-1:0]      fill_tag,
    output logic [SETS*WAYS-1:0]  valid_flat
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  match;

    // Valid bits: cleared by reset or invalidate, set by a completed fill.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else if (fill_en) begin
            vld_q[fill_idx][fill_way] <= 1'b1;
        end
    end

    // Tag storage: written when a fill completes.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx][fill_way] <= fill_tag;
        end
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
        end
        for (genvar s = 0; s < SETS; s++) begin : g_flat
            assign valid_flat[s*WAYS +: WAYS] = vld_q[s];
        end
    endgenerate

    // Encode the matching way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    assign hit     = |match;
    assign set_vld = vld_q[lk_idx];
endmodule

// File: rtl/wtc_data_array.sv
// Line data storage addressed by {set, way, word}, one read port
// (combinational) and one write port. Contents are not reset: a line is only
// read after its valid bit was set by a fill that wrote all of its words.
module wtc_data_array
    import wtc_pkg::*;
#(
    parameter int SETS       = 8,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    localparam int IDX_W     = $clog2(SETS),
    localparam int WORD_W    = $clog2(LINE_WORDS)
) (
    input  logic               clk,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [WAY_W-1:0]   rd_way,
    input  logic [WORD_W-1:0]  rd_word,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WAY_W-1:0]   wr_way,
    input  logic [WORD_W-1:0]  wr_word,
    input  logic [DATA_W-1:0]  wr_data
);
    localparam int ENTRIES = SETS * WAYS * LINE_WORDS;

    logic [DATA_W-1:0] mem_q [ENTRIES];

    // Word write from a fill beat or a write hit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_way, wr_word}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{rd_idx, rd_way, rd_word}];
endmodule

// File: rtl/wtc_plru.sv
// Per-set three-bit replacement tree and victim selection. The victim is the
// lowest-numbered invalid way of the selected set, else the way the tree
// points at. Invalidate-all and reset clear every tree to zero.
module wtc_plru
    import wtc_pkg::*;
#(
    parameter int SETS = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              touch_en,
    input  logic [IDX_W-1:0]  touch_idx,
    input  logic [WAY_W-1:0]  touch_way,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [WAYS-1:0]   set_vld,
    output logic [WAY_W-1:0]  victim
);
    logic [2:0] tree_q [SETS];

    // Tree state: cleared on reset or invalidate, steered on every access.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int s = 0; s < SETS; s++) begin
                tree_q[s] <= 3'b000;
            end
        end else if (touch_en) begin
            tree_q[touch_idx] <= plru_touch(tree_q[touch_idx], touch_way);
        end
    end

    // Victim choice: empty way first (lowest index wins), tree otherwise.
    always_comb begin
        victim = plru_pick(tree_q[sel_idx]);
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_vld[w]) begin
                victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/wt_cache_ctrl.sv
// Four-way write-through data cache controller. Read hits complete in the
// request cycle; cacheable read misses fill a whole line one bus beat at a
// time; uncacheable read misses and all writes make a single bus transfer.
// Assumes the processor holds cpu_* stable from cpu_valid until cpu_ready,
// SETS and LINE_WORDS are powers of two with SETS >= 2 and LINE_WORDS >= 2.
module wt_cache_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SETS       = 8,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic              cpu_cacheable,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int BYTE_W   = $clog2(DATA_W / 8);
    localparam int WORD_W   = $clog2(LINE_WORDS);
    localparam int IDX_W    = $clog2(SETS);
    localparam int LINE_LSB = BYTE_W + WORD_W;
    localparam int TAG_W    = ADDR_W - IDX_W - LINE_LSB;
    localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

    // Request fields
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WORD_W-1:0] req_word;

    assign req_idx  = cpu_addr[LINE_LSB +: IDX_W];
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_word = cpu_addr[BYTE_W +: WORD_W];

    // Controller state
    ctl_state_e        state_q, state_d;
    logic [WORD_W-1:0] beat_q;
    logic [WAY_W-1:0]  victim_q;
    logic              whit_q;
    logic [WAY_W-1:0]  wway_q;
    logic [DATA_W-1:0] resp_q;

    // Array interfaces
    logic                 lk_hit;
    logic [WAY_W-1:0]     hit_way;
    logic [WAYS-1:0]      set_vld;
    logic [SETS*WAYS-1:0] valid_flat;
    logic                 tag_we;
    logic [DATA_W-1:0]    rd_data;
    logic                 dat_we;
    logic [WAY_W-1:0]     dat_way;
    logic [WORD_W-1:0]    dat_word;
    logic [DATA_W-1:0]    dat_wdata;
    logic                 touch_en;
    logic [WAY_W-1:0]     touch_way;
    logic [WAY_W-1:0]     victim;

    wtc_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .inv_all    (inv_all),
        .lk_idx     (req_idx),
        .lk_tag     (req_tag),
        .hit        (lk_hit),
        .hit_way    (hit_way),
        .set_vld    (set_vld),
        .fill_en    (tag_we),
        .fill_idx   (req_idx),
        .fill_way   (victim_q),
        .fill_tag   (req_tag),
        .valid_flat (valid_flat)
    );

    wtc_data_array #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_way  (hit_way),
        .rd_word (req_word),
        .rd_data (rd_data),
        .wr_en   (dat_we),
        .wr_idx  (req_idx),
        .wr_way  (dat_way),
        .wr_word (dat_word),
        .wr_data (dat_wdata)
    );

    wtc_plru #(.SETS(SETS)) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_all   (inv_all),
        .touch_en  (touch_en),
        .touch_idx (req_idx),
        .touch_way (touch_way),
        .sel_idx   (req_idx),
        .set_vld   (set_vld),
        .victim    (victim)
    );

    // Next state, port outputs and array write strobes.
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_rdata = resp_q;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        touch_en  = 1'b0;
        touch_way = hit_way;
        tag_we    = 1'b0;
        dat_we    = 1'b0;
        dat_way   = victim_q;
        dat_word  = beat_q;
        dat_wdata = bus_rdata;
        case (state_q)
            ST_IDLE: begin
                if (cpu_valid) begin
                    if (cpu_write) begin
                        state_d = ST_WRITE;
                    end else if (lk_hit) begin
                        cpu_ready = 1'b1;
                        cpu_rdata = rd_data;
                        touch_en  = 1'b1;
                    end else if (cpu_cacheable) begin
                        state_d = ST_FILL;
                    end else begin
                        state_d = ST_BYPASS;
                    end
                end
            end
            ST_FILL: begin
                bus_valid = 1'b1;
                bus_addr  = {cpu_addr[ADDR_W-1:LINE_LSB], beat_q, {BYTE_W{1'b0}}};
                if (bus_ready) begin
                    dat_we = 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        tag_we    = 1'b1;
                        touch_en  = 1'b1;
                        touch_way = victim_q;
                        state_d   = ST_RESP;
                    end
                end
            end
            ST_BYPASS: begin
                bus_valid = 1'b1;
                if (bus_ready) begin
                    state_d = ST_RESP;
                end
            end
            ST_WRITE: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                if (bus_ready) begin
                    if (whit_q) begin
                        dat_we    = 1'b1;
                        dat_way   = wway_q;
                        dat_word  = req_word;
                        dat_wdata = cpu_wdata;
                        touch_en  = 1'b1;
                        touch_way = wway_q;
                    end
                    state_d = ST_RESP;
                end
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencing registers: state, beat count, latched way choices, response word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            victim_q <= '0;
            whit_q   <= 1'b0;
            wway_q   <= '0;
            resp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                beat_q   <= '0;
                victim_q <= victim;
                whit_q   <= lk_hit;
                wway_q   <= hit_way;
            end
            if (state_q == ST_FILL && bus_ready) begin
                beat_q <= beat_q + 1'b1;
                if (beat_q == req_word) begin
                    resp_q <= bus_rdata;
                end
            end
            if (state_q == ST_BYPASS && bus_ready) begin
                resp_q <= bus_rdata;
            end
        end
    end
endmodule

// File: rtl/wt_cache_ctrl_chk.sv
// Property checker for wt_cache_ctrl, attached by bind. Relies on the same
// processor-side assumption as the controller: requests stay stable until
// cpu_ready.
module wt_cache_ctrl_chk #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int VBITS    = 32,
    parameter int LINE_LSB = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_all,
    input logic              cpu_valid,
    input logic              cpu_write,
    input logic              cpu_cacheable,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_ready,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic [VBITS-1:0]  valid_flat
);
    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

    p_ready_no_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_valid);

    p_ready_has_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid);

    p_bus_same_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_addr[ADDR_W-1:LINE_LSB] == cpu_addr[ADDR_W-1:LINE_LSB]);

    p_bypass_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && !cpu_cacheable |-> bus_addr == cpu_addr);

    p_write_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write |-> cpu_write && bus_addr == cpu_addr && bus_wdata == cpu_wdata);

    p_inv_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> valid_flat == '0);
endmodule

bind wt_cache_ctrl wt_cache_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .VBITS    (SETS * wtc_pkg::WAYS),
    .LINE_LSB (LINE_LSB)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .inv_all       (inv_all),
    .cpu_valid     (cpu_valid),
    .cpu_write     (cpu_write),
    .cpu_cacheable (cpu_cacheable),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_ready     (cpu_ready),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_ready     (bus_ready),
    .valid_flat    (valid_flat)
);

// File: tb/wt_cache_ctrl_bench.sv
// Bench: 4 sets x 4 ways x 4 words, 1 KB bus memory, reference model of
// residency and tree bits computed from the requirements.
module wt_cache_ctrl_bench;
    localparam int SETS = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        inv_all;
    logic        cpu_valid;
    logic        cpu_write;
    logic        cpu_cacheable;
    logic [31:0] cpu_addr;
    logic [31:0] cpu_wdata;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        bus_valid;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ready;
    logic [31:0] bus_rdata;

    always #5 clk = ~clk;

    wt_cache_ctrl #(.ADDR_W(32), .DATA_W(32), .SETS(SETS), .LINE_WORDS(4)) u_wt_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_cacheable(cpu_cacheable),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int failures = 0;

    // Bus memory and responder: one handshake every other cycle.
    logic [31:0] mem [256];
    int          rd_cnt;
    int          wr_cnt;
    logic [31:0] rd_log [4];
    logic [31:0] last_wr_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            rd_cnt    <= 0;
            wr_cnt    <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= (i * 32'h9E3779B9) ^ 32'h5A5A0000;
        end else if (bus_ready) begin
            bus_ready <= 1'b0;
        end else if (bus_valid) begin
            bus_ready <= 1'b1;
            if (bus_write) begin
                mem[bus_addr[9:2]] <= bus_wdata;
                last_wr_addr       <= bus_addr;
                wr_cnt             <= wr_cnt + 1;
            end else begin
                bus_rdata            <= mem[bus_addr[9:2]];
                rd_log[rd_cnt & 3]   <= bus_addr;
                rd_cnt               <= rd_cnt + 1;
            end
        end
    end

    // Reference model state.
    bit         m_vld  [SETS][4];
    int         m_tag  [SETS][4];
    logic [2:0] m_tree [SETS];

    task automatic model_clear();
        for (int s = 0; s < SETS; s++) begin
            m_tree[s] = 3'b000;
            for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
        end
    endtask

    task automatic model_touch(input int s, input int w);
        if (w < 2) begin
            m_tree[s][0] = 1'b1;
            m_tree[s][1] = (w == 0);
        end else begin
            m_tree[s][0] = 1'b0;
            m_tree[s][2] = (w == 2);
        end
    endtask

    function automatic int model_victim(input int s);
        for (int w = 0; w < 4; w++) if (!m_vld[s][w]) return w;
        if (m_tree[s][0] == 1'b0) return m_tree[s][1] ? 1 : 0;
        return m_tree[s][2] ? 3 : 2;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One processor access; called at a falling edge, returns at a falling edge.
    task automatic access(input string req, input bit wr, input bit cach,
                          input int tg, input int st, input int wd, input logic [31:0] wdat);
        logic [31:0] a;
        logic [31:0] exp_data;
        logic [31:0] got;
        int hw, vict, exp_rd, exp_wr, base_rd, base_wr, waits;
        a        = 32'(tg * 64 + st * 16 + wd * 4);
        exp_data = mem[a[9:2]];
        base_rd  = rd_cnt;
        base_wr  = wr_cnt;
        hw       = -1;
        exp_rd   = 0;
        exp_wr   = 0;
        for (int w = 0; w < 4; w++) if (m_vld[st][w] && m_tag[st][w] == tg) hw = w;
        if (!wr) begin
            if (hw >= 0) begin
                model_touch(st, hw);
            end else if (cach) begin
                exp_rd = 4;
                vict = model_victim(st);
                m_vld[st][vict] = 1'b1;
                m_tag[st][vict] = tg;
                model_touch(st, vict);
            end else begin
                exp_rd = 1;
            end
        end else begin
            exp_wr = 1;
            if (hw >= 0) model_touch(st, hw);
        end
        cpu_valid     = 1'b1;
        cpu_write     = wr;
        cpu_cacheable = cach;
        cpu_addr      = a;
        cpu_wdata     = wdat;
        waits         = 0;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            waits++;
        end
        got = cpu_rdata;
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        if (!wr) chk(req, "read data", got, exp_data);
        chk(req, "bus read beats", rd_cnt - base_rd, exp_rd);
        chk(req, "bus write beats", wr_cnt - base_wr, exp_wr);
        if (!wr && hw >= 0) chk(req, "hit wait cycles", waits, 0);
        if (wr) begin
            chk(req, "bus write address", last_wr_addr, a);
            chk(req, "memory after write", mem[a[9:2]], wdat);
        end
        if (exp_rd == 4) begin
            for (int k = 0; k < 4; k++)
                chk(req, "fill beat address", rd_log[(base_rd + k) & 3], {a[31:4], 4'h0} + 32'(4 * k));
        end
    endtask

    task automatic invalidate();
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        model_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0; inv_all = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0;
        cpu_cacheable = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        model_clear();
        repeat (3) @(negedge clk);
        chk("R12", "cpu_ready in reset", cpu_ready, 0);
        chk("R12", "bus_valid in reset", bus_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "bus_valid after reset", bus_valid, 0);

        // R2 first fill, R7 remaining ways of an empty set
        access("R2", 0, 1, 0, 0, 1, 0);
        for (int t = 1; t < 4; t++) access("R7", 0, 1, t, 0, t, 0);
        for (int t = 0; t < 4; t++) access("R1", 0, 1, t, 0, 3 - t, 0);
        // R8 full set eviction, then probe survivors
        access("R8", 0, 1, 4, 0, 0, 0);
        for (int t = 0; t < 5; t++) access("R8", 0, 1, t, 0, 2, 0);
        // R3 uncacheable read miss twice, then cacheable fill
        access("R3", 0, 0, 0, 2, 1, 0);
        access("R3", 0, 0, 0, 2, 1, 0);
        access("R3", 0, 1, 0, 2, 2, 0);
        // R6 write miss, then full fill
        access("R6", 1, 1, 0, 1, 2, 32'hDEAD0001);
        access("R6", 0, 1, 0, 1, 2, 0);
        // R5 write hits (cacheable and not), then read hits
        access("R5", 1, 1, 0, 1, 2, 32'hBEEF0002);
        access("R5", 0, 1, 0, 1, 2, 0);
        access("R5", 1, 0, 0, 1, 3, 32'h12340003);
        access("R5", 0, 1, 0, 1, 3, 0);
        // R4 write to an absent line
        access("R4", 1, 0, 5, 3, 0, 32'h0F0F0F0F);
        // R9 hit touches steer eviction in set 3
        for (int t = 0; t < 4; t++) access("R9", 0, 1, t, 3, 0, 0);
        access("R9", 0, 1, 0, 3, 1, 0);
        access("R9", 1, 1, 2, 3, 1, 32'h22220000);
        access("R9", 0, 1, 4, 3, 0, 0);
        for (int t = 0; t < 5; t++) access("R9", 0, 1, t, 3, 3, 0);
        // R10 invalidate drops lines and tree state
        invalidate();
        access("R10", 0, 1, 0, 1, 2, 0);
        for (int t = 1; t < 5; t++) access("R10", 0, 1, t, 1, 0, 0);
        access("R10", 0, 1, 0, 1, 1, 0);

        // Pseudo-random stream over 4 sets x 6 tags
        lfsr = 32'h1ACE5EED;
        for (int n = 0; n < 800; n++) begin
            int op;
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            op = int'(lfsr[31:28]);
            if (n % 200 == 199) invalidate();
            if (op < 10)
                access("R9", 0, 1, int'(lfsr[7:0]) % 6, int'(lfsr[9:8]), int'(lfsr[11:10]), 0);
            else if (op < 12)
                access("R3", 0, 0, int'(lfsr[7:0]) % 6, int'(lfsr[9:8]), int'(lfsr[11:10]), 0);
            else
                access("R4", 1, lfsr[12], int'(lfsr[7:0]) % 6, int'(lfsr[9:8]), int'(lfsr[11:10]), lfsr ^ 32'hA5A5A5A5);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule